// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

This block sits beside a receive MAC and watches the incoming byte stream while a sleep-detection mode is on. Software arms the mode through a set/clear write port. While the mode is armed, every received frame is marked for discard, and the stream is searched for the wake pattern: six 0xFF sync bytes followed by sixteen back-to-back copies of the station address. The pattern may start at any byte offset in the frame.

A frame wakes the system only when three conditions hold. Its destination must be the station address, or a group address (multicast or broadcast). It must be at least 14 bytes long. Its frame-check flag must be good at end of frame. On such a frame the block raises a one-cycle wake pulse and clears its own enable, so later frames pass through normally. Software can leave the mode at any time by writing clear. A clear that arrives while a frame is in progress cancels any wake for that frame.

Top module: `wol_magic_detect`

## Requirements
- R1: After reset, `mode_en`, `wake_irq` and `rx_discard` are all 0.
- R2: A pulse on `en_set` makes `mode_en` 1 from the next cycle. A pulse on `en_clr` makes it 0 from the next cycle. When both are high in the same cycle, the clear wins.
- R3: If `mode_en` is 1 when a frame's first byte arrives, `rx_discard` is high with every valid byte of that frame, including the frame that causes the wake. If `mode_en` is 0 at that point, `rx_discard` stays low for the whole frame.
- R4: A qualifying frame holds the pattern 6×0xFF followed by 16 copies of `station_addr`, sent most significant byte first (bits 47:40 first). For such a frame, `wake_irq` is high for exactly the one cycle after the last-byte cycle, and `mode_en` reads 0 from that same cycle.
- R5: A sync run of more than six 0xFF bytes before the first address copy still leads to detection.
- R6: A byte that breaks a partial match is re-examined as a possible start of a new sync run. If that byte is 0xFF, it counts as the first sync byte.
- R7: Only frames whose first six bytes equal `station_addr`, or whose first byte has bit 0 set (multicast, broadcast), can wake. A frame sent to another unicast address leaves `mode_en` at 1 and gives no pulse.
- R8: A frame whose `rx_fcs_ok` is low on its last byte never wakes, and `mode_en` stays 1.
- R9: A frame shorter than 14 bytes never wakes, even if it contains the whole pattern. A 14-byte frame carrying it does wake.
- R10: An `en_clr` during a frame cancels detection for that frame, even if `en_set` follows before its last byte. `mode_en` then ends the frame at 1 with no pulse.
- R11: Once a wake has cleared the mode, later frames are not marked for discard and produce no pulse.
- R12: The match found on the pattern's final byte is held through any trailing bytes until end of frame. A pattern split across two frames does not wake, because all match state restarts at each frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_fcs_ok | input | 1 | Frame check good; sampled with the last byte |
| station_addr | input | 48 | Station address, bits 47:40 sent first |
| en_set | input | 1 | Write pulse that turns the mode on |
| en_clr | input | 1 | Write pulse that turns the mode off (abort) |
| rx_discard | output | 1 | Current byte belongs to a frame to be dropped |
| mode_en | output | 1 | Detection mode is armed |
| wake_irq | output | 1 | One-cycle wake event |

## Verification
The bench builds the block twice. The first instance keeps the default of sixteen address copies, so the full 102-byte pattern is exercised: at a payload offset, after a long sync run, after a restart, split across two frames, and under abort. The second instance uses a single address copy, which shrinks the pattern to 12 bytes. That makes the 14-byte minimum-length rule reachable: a broadcast frame whose header itself forms the pattern is sent at 13 and at 14 bytes.

// File: rtl/wol_pkg.sv
// Shared types and constants for the wake-on-LAN detector.
// Assumes byte-wide receive data, one beat per valid cycle.
package wol_pkg;

    typedef logic [7:0] octet_t;

    // One receive beat as seen by the sub-blocks.
    typedef struct packed {
        logic   valid;
        logic   sof;
        logic   eof;
        octet_t data;
    } rx_beat_t;

    localparam octet_t SYNC_BYTE = 8'hFF;

endpackage

// File: rtl/wol_addr_qual.sv
// Destination qualification and length tracking.
// Compares the first ADDR_BYTES bytes of each frame with the station
// address and notes the group bit of the first byte. Counts bytes,
// saturating at MIN_LEN. frame_ok is valid on the current beat and
// assumes MIN_LEN >= ADDR_BYTES, so the destination is complete then.
module wol_addr_qual
    import wol_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int MIN_LEN    = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  rx_beat_t                beat,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    output logic                    frame_ok
);

    localparam int IW = $clog2(MIN_LEN + 1);
    localparam int PW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    octet_t        addr_b [ADDR_BYTES];
    logic [IW-1:0] idx_q, cur_idx;
    logic          ucast_q, mcast_q, ucast_d, mcast_d;

    // Split the station address into bytes in transmission order.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_ab
        assign addr_b[g] = station_addr[(ADDR_BYTES-1-g)*8 +: 8];
    end

    // Current byte index and next destination flags.
    always_comb begin
        cur_idx = (beat.valid && beat.sof) ? '0 : idx_q;
        ucast_d = ucast_q;
        mcast_d = mcast_q;
        if (beat.valid && cur_idx < IW'(ADDR_BYTES)) begin
            ucast_d = ((cur_idx == '0) ? 1'b1 : ucast_q)
                    && (beat.data == addr_b[cur_idx[PW-1:0]]);
            if (cur_idx == '0) mcast_d = beat.data[0];
        end
        frame_ok = (cur_idx >= IW'(MIN_LEN - 1)) && (ucast_q || mcast_q);
    end

    // Byte counter and destination flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            ucast_q <= 1'b0;
            mcast_q <= 1'b0;
        end else if (beat.valid) begin
            idx_q   <= (cur_idx == IW'(MIN_LEN)) ? cur_idx : cur_idx + 1'b1;
            ucast_q <= ucast_d;
            mcast_q <= mcast_d;
        end
    end

    p_idx_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IW'(MIN_LEN));

endmodule

// File: rtl/wol_pattern_match.sv
// Sliding search for SYNC_LEN sync bytes followed by ADDR_REPS copies of
// the station address, at any offset of a frame. A mismatching byte
// restarts the search with itself as a candidate sync byte. Extra sync
// bytes after a full sync run keep the run alive. The hit is held until
// the next start of frame.
module wol_pattern_match
    import wol_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int SYNC_LEN   = 6,
    parameter int ADDR_REPS  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  rx_beat_t                beat,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    output logic                    pat_hit
);

    localparam int PAT_LEN = SYNC_LEN + ADDR_BYTES * ADDR_REPS;
    localparam int CW      = $clog2(PAT_LEN + 1);
    localparam int PW      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    octet_t        addr_b [ADDR_BYTES];
    logic [CW-1:0] cnt_q, cur_cnt, cnt_d;
    logic [PW-1:0] pos_q, cur_pos, pos_d;
    logic          hit_q, cur_hit, hit_d;
    logic          is_sync, in_sync, match, last;
    octet_t        expect_b;

    // Address bytes in transmission order, most significant first.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_ab
        assign addr_b[g] = station_addr[(ADDR_BYTES-1-g)*8 +: 8];
    end

    // Compare the current byte and work out the next match position.
    always_comb begin
        if (beat.valid && beat.sof) begin
            cur_cnt = '0;
            cur_pos = '0;
            cur_hit = 1'b0;
        end else begin
            cur_cnt = cnt_q;
            cur_pos = pos_q;
            cur_hit = hit_q;
        end
        in_sync  = cur_cnt < CW'(SYNC_LEN);
        expect_b = in_sync ? SYNC_BYTE : addr_b[cur_pos];
        is_sync  = beat.data == SYNC_BYTE;
        match    = beat.data == expect_b;
        last     = cur_cnt == CW'(PAT_LEN - 1);
        cnt_d    = cur_cnt;
        pos_d    = cur_pos;
        hit_d    = cur_hit;
        if (!cur_hit) begin
            if (match) begin
                if (last) begin
                    hit_d = 1'b1;
                end else begin
                    cnt_d = cur_cnt + 1'b1;
                    if (!in_sync)
                        pos_d = (cur_pos == PW'(ADDR_BYTES - 1)) ? '0 : cur_pos + 1'b1;
                end
            end else if (!(cur_cnt == CW'(SYNC_LEN) && is_sync)) begin
                cnt_d = is_sync ? CW'(1) : '0;
                pos_d = '0;
            end
        end
        pat_hit = cur_hit || (beat.valid && match && last);
    end

    // Match state registers, advanced once per valid byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pos_q <= '0;
            hit_q <= 1'b0;
        end else if (beat.valid) begin
            cnt_q <= cnt_d;
            pos_q <= pos_d;
            hit_q <= hit_d;
        end
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(PAT_LEN));

    p_hit_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && !(beat.valid && beat.sof)) |=> hit_q);

endmodule

// File: rtl/wol_mode_ctrl.sv
// Enable register, per-frame arming, discard marking and wake pulse.
// Assumes frame_ok and pat_hit are valid on the last byte of a frame.
// A clear wins over a set. A frame is armed only if the mode was on at
// its first byte and no clear has arrived since.
module wol_mode_ctrl
    import wol_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rx_beat_t beat,
    input  logic     rx_fcs_ok,
    input  logic     en_set,
    input  logic     en_clr,
    input  logic     frame_ok,
    input  logic     pat_hit,
    output logic     rx_discard,
    output logic     mode_en,
    output logic     wake_irq
);

    logic mode_q, armed_q, disc_q, wake_q;
    logic first, armed_now, wake_fire;

    // Decide whether this byte completes a wake frame.
    always_comb begin
        first      = beat.valid && beat.sof;
        armed_now  = first ? mode_q : armed_q;
        wake_fire  = beat.valid && beat.eof && armed_now && mode_q && !en_clr
                     && rx_fcs_ok && frame_ok && pat_hit;
        rx_discard = beat.valid && (first ? mode_q : disc_q);
    end

    // Mode, arming, discard latch and wake pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            armed_q <= 1'b0;
            disc_q  <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            if (en_clr || wake_fire) mode_q <= 1'b0;
            else if (en_set)         mode_q <= 1'b1;
            if (en_clr)              armed_q <= 1'b0;
            else if (first)          armed_q <= mode_q;
            if (first)               disc_q <= mode_q;
            wake_q <= wake_fire;
        end
    end

    assign mode_en  = mode_q;
    assign wake_irq = wake_q;

    p_clr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !mode_q);

    p_wake_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q);

    p_wake_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> !mode_q);

    p_wake_needs_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_q) |-> $past(mode_q && !en_clr));

endmodule

// File: rtl/wol_magic_detect.sv
// Top of the wake-on-LAN pattern detector. Bundles the receive beat,
// then connects destination qualification, the pattern search and
// the mode control. Assumes rx_sof/rx_eof/rx_fcs_ok are meaningful
// only with rx_valid.
module wol_magic_detect
    import wol_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int SYNC_LEN   = 6,
    parameter int ADDR_REPS  = 16,
    parameter int MIN_LEN    = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              rx_data,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic                    rx_fcs_ok,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic                    en_set,
    input  logic                    en_clr,
    output logic                    rx_discard,
    output logic                    mode_en,
    output logic                    wake_irq
);

    rx_beat_t beat;
    logic     frame_ok, pat_hit;

    // Gather the receive inputs into one beat.
    always_comb begin
        beat.valid = rx_valid;
        beat.sof   = rx_sof;
        beat.eof   = rx_eof;
        beat.data  = rx_data;
    end

    wol_addr_qual #(.ADDR_BYTES(ADDR_BYTES), .MIN_LEN(MIN_LEN)) u_qual (
        .clk(clk), .rst_n(rst_n), .beat(beat),
        .station_addr(station_addr), .frame_ok(frame_ok));

    wol_pattern_match #(.ADDR_BYTES(ADDR_BYTES), .SYNC_LEN(SYNC_LEN),
                        .ADDR_REPS(ADDR_REPS)) u_match (
        .clk(clk), .rst_n(rst_n), .beat(beat),
        .station_addr(station_addr), .pat_hit(pat_hit));

    wol_mode_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .beat(beat), .rx_fcs_ok(rx_fcs_ok),
        .en_set(en_set), .en_clr(en_clr), .frame_ok(frame_ok),
        .pat_hit(pat_hit), .rx_discard(rx_discard), .mode_en(mode_en),
        .wake_irq(wake_irq));

endmodule

// File: tb/wol_magic_detect_tb.sv
module wol_magic_detect_tb;

    localparam int          CLK_NS = 4;
    localparam logic [47:0] STA    = 48'h021A3C4D5E6F;
    localparam logic [47:0] OTHER  = 48'h00AABBCCDDEE;
    localparam logic [47:0] MCAST  = 48'h01005E000001;
    localparam logic [47:0] BCAST  = 48'hFFFFFFFFFFFF;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_fcs_ok = 0;
    logic       en_set = 0, en_clr = 0;
    logic       rx_discard, mode_en, wake_irq;
    logic       rx_discard_r1, mode_en_r1, wake_irq_r1;

    int n_tests = 0, n_fail = 0;
    logic [7:0] fb [0:511];
    int  flen;
    bit  disc_all, disc_any, w0, w1, w0_next, m0;

    always #(CLK_NS/2) clk = ~clk;

    wol_magic_detect u_dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_fcs_ok(rx_fcs_ok),
        .station_addr(STA), .en_set(en_set), .en_clr(en_clr),
        .rx_discard(rx_discard), .mode_en(mode_en), .wake_irq(wake_irq));

    wol_magic_detect #(.ADDR_REPS(1)) u_dut_r1 (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_fcs_ok(rx_fcs_ok),
        .station_addr(STA), .en_set(en_set), .en_clr(en_clr),
        .rx_discard(rx_discard_r1), .mode_en(mode_en_r1), .wake_irq(wake_irq_r1));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic f_clear(); flen = 0; endtask
    task automatic f_byte(input logic [7:0] b); fb[flen] = b; flen++; endtask
    task automatic f_addr(input logic [47:0] a);
        for (int i = 5; i >= 0; i--) f_byte(a[i*8 +: 8]);
    endtask
    task automatic f_hdr(input logic [47:0] da);
        f_addr(da); f_addr(48'h0A0B0C0D0E0F); f_byte(8'h08); f_byte(8'h00);
    endtask
    task automatic f_junk(input int n);
        for (int i = 0; i < n; i++) f_byte(8'h30 + 8'(i));
    endtask
    task automatic f_ff(input int n);
        for (int i = 0; i < n; i++) f_byte(8'hFF);
    endtask
    task automatic f_copies(input int n);
        for (int i = 0; i < n; i++) f_addr(STA);
    endtask

    task automatic enable();
        @(negedge clk); en_set = 1;
        @(negedge clk); en_set = 0;
    endtask

    // Send the buffered frame; pulse clear/set with byte index ci/si.
    task automatic send(input bit fcs, input int ci, input int si);
        disc_all = 1; disc_any = 0;
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == flen - 1);
            rx_data = fb[i]; rx_fcs_ok = fcs && (i == flen - 1);
            en_clr = (i == ci); en_set = (i == si);
            #1;
            if (rx_discard) disc_any = 1; else disc_all = 0;
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_fcs_ok = 0;
        en_clr = 0; en_set = 0;
        #1; w0 = wake_irq; w1 = wake_irq_r1; m0 = mode_en;
        @(negedge clk); #1; w0_next = wake_irq;
    endtask

    task automatic t_reset();
        chk(mode_en == 0, "R1", "mode_en", int'(mode_en), 0);
        chk(wake_irq == 0, "R1", "wake_irq", int'(wake_irq), 0);
        chk(rx_discard == 0, "R1", "rx_discard", int'(rx_discard), 0);
    endtask

    task automatic t_enable();
        enable(); #1;
        chk(mode_en == 1, "R2", "mode after set", int'(mode_en), 1);
        @(negedge clk); en_set = 1; en_clr = 1;
        @(negedge clk); en_set = 0; en_clr = 0; #1;
        chk(mode_en == 0, "R2", "clear beats set", int'(mode_en), 0);
    endtask

    task automatic t_unicast();  // R4 R3 R12: pattern at offset, trailing bytes
        enable();
        f_clear(); f_hdr(STA); f_junk(5); f_ff(6); f_copies(16); f_junk(4);
        send(1, -1, -1);
        chk(w0 == 1, "R4", "wake at offset", int'(w0), 1);
        chk(w0_next == 0, "R4", "wake one cycle", int'(w0_next), 0);
        chk(m0 == 0, "R4", "mode cleared", int'(m0), 0);
        chk(disc_all == 1, "R3", "wake frame discarded", int'(disc_all), 1);
        chk(w0 == 1, "R12", "hit held to eof", int'(w0), 1);
    endtask

    task automatic t_after_wake();  // R11 R3
        f_clear(); f_hdr(STA); f_ff(6); f_copies(16);
        send(1, -1, -1);
        chk(disc_any == 0, "R11", "no discard after wake", int'(disc_any), 0);
        chk(w0 == 0, "R11", "no wake when off", int'(w0), 0);
        chk(disc_any == 0, "R3", "mode off keeps frame", int'(disc_any), 0);
    endtask

    task automatic t_long_sync();  // R5
        enable();
        f_clear(); f_hdr(STA); f_ff(9); f_copies(16);
        send(1, -1, -1);
        chk(w0 == 1, "R5", "long sync run", int'(w0), 1);
    endtask

    task automatic t_restart();  // R6
        enable();
        f_clear(); f_hdr(STA); f_ff(6); f_byte(STA[47:40]); f_byte(STA[39:32]);
        f_ff(6); f_copies(16);
        send(1, -1, -1);
        chk(w0 == 1, "R6", "breaking FF starts run", int'(w0), 1);
    endtask

    task automatic t_dest();  // R7
        enable();
        f_clear(); f_hdr(OTHER); f_ff(6); f_copies(16);
        send(1, -1, -1);
        chk(w0 == 0, "R7", "foreign unicast wake", int'(w0), 0);
        chk(m0 == 1, "R7", "foreign unicast mode", int'(m0), 1);
        f_clear(); f_hdr(MCAST); f_ff(6); f_copies(16);
        send(1, -1, -1);
        chk(w0 == 1, "R7", "multicast wake", int'(w0), 1);
        enable();
        f_clear(); f_ff(6); f_copies(16); f_junk(3);
        send(1, -1, -1);
        chk(w0 == 1, "R7", "broadcast at offset 0", int'(w0), 1);
    endtask

    task automatic t_fcs();  // R8
        enable();
        f_clear(); f_hdr(BCAST); f_ff(6); f_copies(16);
        send(0, -1, -1);
        chk(w0 == 0, "R8", "bad FCS wake", int'(w0), 0);
        chk(m0 == 1, "R8", "bad FCS mode", int'(m0), 1);
        send(1, -1, -1);
        chk(w0 == 1, "R8", "good FCS wake", int'(w0), 1);
    endtask

    task automatic t_split();  // R12
        enable();
        f_clear(); f_hdr(STA); f_ff(6); f_copies(8);
        send(1, -1, -1);
        f_clear(); f_copies(8); f_junk(8);
        send(1, -1, -1);
        chk(w0 == 0, "R12", "split pattern", int'(w0), 0);
        chk(m0 == 1, "R12", "split pattern mode", int'(m0), 1);
    endtask

    task automatic t_abort();  // R10
        f_clear(); f_hdr(STA); f_ff(6); f_copies(16);
        send(1, 20, 30);
        chk(w0 == 0, "R10", "clear mid-frame", int'(w0), 0);
        chk(m0 == 1, "R10", "re-set mode", int'(m0), 1);
        chk(disc_all == 1, "R10", "frame still discarded", int'(disc_all), 1);
        send(1, -1, -1);
        chk(w0 == 1, "R10", "next frame wakes", int'(w0), 1);
    endtask

    task automatic t_short();  // R9 on the single-copy instance
        enable();
        f_clear(); f_ff(6); f_copies(1); f_junk(1);
        send(1, -1, -1);
        chk(w1 == 0, "R9", "13-byte frame", int'(w1), 0);
        chk(mode_en_r1 == 1, "R9", "13-byte mode", int'(mode_en_r1), 1);
        f_byte(8'h55);
        send(1, -1, -1);
        chk(w1 == 1, "R9", "14-byte frame", int'(w1), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        t_reset();
        t_enable();
        t_unicast();
        t_after_wake();
        t_long_sync();
        t_restart();
        t_dest();
        t_fcs();
        t_split();
        t_abort();
        t_short();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule